// File: doc/BRIEF.md
# Inter-Processor Message Router

This block carries short messages between one control node and a set of processing units. Node 0 is the control node and nodes 1 to NUM_PU are the processing units. Each node has a send port and a receive port. The send port carries a valid/ready handshake with a destination index, a kind code and a payload. The receive port is a small FIFO that the node drains with a pop strobe. The router resolves contention for each receiver with round-robin arbiters and applies backpressure to the senders that lose.

There are four kinds of message:

- **Point-to-point:** lets a pair of units synchronise.
- **Broadcast:** reaches every other node in the same cycle.
- **Work item:** posted by the control node into a shared queue and handed to whichever waiting unit asks for work.
- **Interrupt:** skips the FIFOs. It raises a branch request at the destination node and carries the payload as the branch target. The request is held until the node acknowledges it.

Because only one interrupt can be pending per destination, interrupts sent by units to the control node give serialised, one-at-a-time access to shared state, which software can use as a semaphore. Destination indices must be below NUM_PU+1.

Top module: `msg_router`

## Requirements
- R1: While reset is asserted and after its release, no receive port is valid, no branch request is raised and no work grant is given.
- R2: A message of kind 0 (point-to-point) accepted from node s with destination d appears at the head of node d's receive port on the cycle after acceptance. It appears there only, with source s, kind 0 and the payload. Each receive port returns its messages in arrival order.
- R3: A message of kind 1 (broadcast) is written into the receive FIFO of every node except its sender in one single cycle, with source and kind 1. It is accepted only when all of those FIFOs have room. While any broadcast is being requested, no point-to-point message enters any FIFO.
- R4: A message of kind 2 (work item) from node 0 enters the work queue of depth QDEPTH and reaches no receive port. Node 0 is stalled while the queue is full. A kind-2 message from any other node is accepted and discarded.
- R5: When the queue holds an item and units assert work_req, one unit is granted per cycle. Grants go in round-robin order over the requesters, where unit p is bit p. Items are handed out oldest first. The grant shows on work_valid as a one-cycle pulse, with work_data, on the cycle after the grant. Only a requesting unit can receive one.
- R6: A message of kind 3 (interrupt) to node d sets brq_valid[d], with brq_addr equal to the payload and brq_src equal to the sender. It writes no receive FIFO. The request holds, stable, until brq_ack[d]. A further interrupt to d is stalled while one is pending, and contenders are served in round-robin order.
- R7: When several senders compete for the same receiver, a round-robin pointer picks the lowest requesting index at or above the pointer, wrapping around. The pointer starts at 0 and moves to one past each winner. Losing senders see snd_ready low.
- R8: A point-to-point message to a receiver whose FIFO holds FDEPTH entries is stalled, and it is accepted once an entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_valid | input | NODES | Per-node send request |
| snd_ready | output | NODES | Per-node send accepted this cycle |
| snd_dest | input | NODES*IW | Per-node destination index |
| snd_kind | input | NODES*2 | Per-node kind: 0 point-to-point, 1 broadcast, 2 work item, 3 interrupt |
| snd_data | input | NODES*PW | Per-node payload or branch target |
| rcv_valid | output | NODES | Receive FIFO non-empty |
| rcv_pop | input | NODES | Remove head entry |
| rcv_src | output | NODES*IW | Sender index of head entry |
| rcv_kind | output | NODES*2 | Kind of head entry |
| rcv_data | output | NODES*PW | Payload of head entry |
| brq_valid | output | NODES | Branch request pending |
| brq_ack | input | NODES | Branch request taken |
| brq_addr | output | NODES*PW | Branch target address |
| brq_src | output | NODES*IW | Node that raised the branch request |
| work_req | input | NUM_PU | Unit waiting for a work item |
| work_valid | output | NUM_PU | One-cycle work grant per unit |
| work_data | output | PW | Payload of the granted work item |

## Verification
The bench builds the router with three units (four nodes), an 8-bit payload, and a depth of four for both the receive FIFOs and the work queue. With four nodes, all sixteen sender/receiver pairs and every broadcast source can be swept exhaustively. The small depths mean that a full FIFO, a full work queue and a broadcast held back by one full receiver are each reached after only a handful of messages. Round-robin order is checked from a known pointer after reset, and expected readiness patterns and grant sequences are worked out in the bench from the pointer rule.

// File: rtl/msg_router_pkg.sv
package msg_router_pkg;

  typedef enum logic [1:0] {
    MK_DIRECT = 2'd0,
    MK_BCAST  = 2'd1,
    MK_WORK   = 2'd2,
    MK_IRQ    = 2'd3
  } msg_kind_e;

  // Position of the set bit of a one-hot vector (0 when none is set).
  function automatic int unsigned oh_index(input logic [31:0] oh);
    int unsigned idx;
    idx = 0;
    for (int i = 0; i < 32; i++) begin
      if (oh[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/msg_rr_arb.sv
module msg_rr_arb #(
  parameter int N = 4,
  localparam int PTRW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         take,
  output logic [N-1:0] gnt,
  output logic         any_req
);
  import msg_router_pkg::*;

  logic [PTRW-1:0] ptr;

  // Lowest requester at or above p; otherwise lowest requester overall.
  function automatic logic [N-1:0] rr_pick(input logic [N-1:0] r,
                                           input logic [PTRW-1:0] p);
    logic [N-1:0] mask;
    logic [N-1:0] hi;
    mask = ~((N'(1) << p) - N'(1));
    hi   = r & mask;
    if (hi != '0) return hi & (~hi + N'(1));
    return r & (~r + N'(1));
  endfunction

  function automatic logic [PTRW-1:0] after(input logic [N-1:0] g);
    int unsigned idx;
    idx = oh_index(32'(g));
    if (idx == N - 1) return '0;
    return PTRW'(idx + 1);
  endfunction

  always_comb begin
    gnt     = rr_pick(req, ptr);
    any_req = (req != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (take && any_req) ptr <= after(gnt);
  end

endmodule

// File: rtl/msg_fifo.sv
module msg_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  always_comb begin
    empty   = (cnt == '0);
    full    = (cnt == CW'(DEPTH));
    do_push = push && !full;
    do_pop  = pop && !empty;
    dout    = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/msg_work_pool.sv
module msg_work_pool #(
  parameter int NPU    = 3,
  parameter int PW     = 16,
  parameter int QDEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           post,
  input  logic [PW-1:0]  post_data,
  output logic           full,
  input  logic [NPU-1:0] req,
  output logic [NPU-1:0] wvalid,
  output logic [PW-1:0]  wdata
);

  logic [PW-1:0]  head;
  logic           q_empty;
  logic [NPU-1:0] gnt;
  logic           any_req;
  logic           fire;

  assign fire = any_req && !q_empty;

  msg_fifo #(.W(PW), .DEPTH(QDEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (post),
    .din   (post_data),
    .pop   (fire),
    .dout  (head),
    .empty (q_empty),
    .full  (full)
  );

  msg_rr_arb #(.N(NPU)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .take    (fire),
    .gnt     (gnt),
    .any_req (any_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wvalid <= '0;
      wdata  <= '0;
    end else begin
      wvalid <= fire ? gnt : '0;
      if (fire) wdata <= head;
    end
  end

endmodule

// File: rtl/msg_router.sv
module msg_router #(
  parameter int NUM_PU = 3,
  parameter int PW     = 16,
  parameter int FDEPTH = 4,
  parameter int QDEPTH = 4,
  localparam int NODES = NUM_PU + 1,
  localparam int IW    = $clog2(NODES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NODES-1:0]    snd_valid,
  output logic [NODES-1:0]    snd_ready,
  input  logic [NODES*IW-1:0] snd_dest,
  input  logic [NODES*2-1:0]  snd_kind,
  input  logic [NODES*PW-1:0] snd_data,
  output logic [NODES-1:0]    rcv_valid,
  input  logic [NODES-1:0]    rcv_pop,
  output logic [NODES*IW-1:0] rcv_src,
  output logic [NODES*2-1:0]  rcv_kind,
  output logic [NODES*PW-1:0] rcv_data,
  output logic [NODES-1:0]    brq_valid,
  input  logic [NODES-1:0]    brq_ack,
  output logic [NODES*PW-1:0] brq_addr,
  output logic [NODES*IW-1:0] brq_src,
  input  logic [NUM_PU-1:0]   work_req,
  output logic [NUM_PU-1:0]   work_valid,
  output logic [PW-1:0]       work_data
);
  import msg_router_pkg::*;

  localparam int EW = IW + 2 + PW;

  // Per-sender decode
  logic [IW-1:0] dest_s [NODES];
  logic [1:0]    kind_s [NODES];
  logic [PW-1:0] data_s [NODES];
  logic [NODES-1:0] is_dir, is_bc, is_work, is_irq;

  always_comb begin
    for (int s = 0; s < NODES; s++) begin
      dest_s[s]  = snd_dest[s*IW +: IW];
      kind_s[s]  = snd_kind[s*2 +: 2];
      data_s[s]  = snd_data[s*PW +: PW];
      is_dir[s]  = snd_valid[s] && (kind_s[s] == 2'(MK_DIRECT));
      is_bc[s]   = snd_valid[s] && (kind_s[s] == 2'(MK_BCAST));
      is_work[s] = snd_valid[s] && (kind_s[s] == 2'(MK_WORK));
      is_irq[s]  = snd_valid[s] && (kind_s[s] == 2'(MK_IRQ));
    end
  end

  // Internal events, brought out by name for the checker
  logic [NODES-1:0] fifo_push, fifo_full, fifo_empty;
  logic [NODES-1:0] dir_fire, dir_pend;
  logic [NODES-1:0] irq_fire, irq_pend;
  logic [NODES-1:0] bc_gnt;
  logic             bc_pend, bc_fire;
  logic [NODES-1:0] dgnt [NODES];
  logic [NODES-1:0] igrant [NODES];

  // Broadcast: one source at a time, fires only when every other FIFO has room
  msg_rr_arb #(.N(NODES)) u_bc_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (is_bc),
    .take    (bc_fire),
    .gnt     (bc_gnt),
    .any_req (bc_pend)
  );

  logic [EW-1:0] bc_entry;

  function automatic logic bc_room_ok(input logic [NODES-1:0] src_oh,
                                      input logic [NODES-1:0] full_v);
    return ((~src_oh) & full_v) == '0;
  endfunction

  always_comb begin
    bc_fire  = bc_pend && bc_room_ok(bc_gnt, fifo_full);
    bc_entry = '0;
    for (int s = 0; s < NODES; s++) begin
      if (bc_gnt[s]) bc_entry = {IW'(s), 2'(MK_BCAST), data_s[s]};
    end
  end

  // Per-receiver delivery
  for (genvar r = 0; r < NODES; r++) begin : g_rx
    logic [NODES-1:0] dreq, ireq;
    logic [EW-1:0]    dir_entry, fifo_din, head;
    logic [PW-1:0]    irq_addr;
    logic [IW-1:0]    irq_src;
    logic             brq_q;
    logic [PW-1:0]    brq_addr_q;
    logic [IW-1:0]    brq_src_q;

    always_comb begin
      dir_entry = '0;
      irq_addr  = '0;
      irq_src   = '0;
      for (int s = 0; s < NODES; s++) begin
        dreq[s] = is_dir[s] && (dest_s[s] == IW'(r));
        ireq[s] = is_irq[s] && (dest_s[s] == IW'(r));
        if (dgnt[r][s]) dir_entry = {IW'(s), 2'(MK_DIRECT), data_s[s]};
        if (igrant[r][s]) begin
          irq_addr = data_s[s];
          irq_src  = IW'(s);
        end
      end
    end

    msg_rr_arb #(.N(NODES)) u_dir_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (dreq),
      .take    (dir_fire[r]),
      .gnt     (dgnt[r]),
      .any_req (dir_pend[r])
    );

    assign dir_fire[r]  = dir_pend[r] && !fifo_full[r] && !bc_pend;
    assign fifo_push[r] = dir_fire[r] || (bc_fire && !bc_gnt[r]);
    assign fifo_din     = bc_fire ? bc_entry : dir_entry;

    msg_fifo #(.W(EW), .DEPTH(FDEPTH)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push[r]),
      .din   (fifo_din),
      .pop   (rcv_pop[r]),
      .dout  (head),
      .empty (fifo_empty[r]),
      .full  (fifo_full[r])
    );

    assign rcv_valid[r]           = !fifo_empty[r];
    assign rcv_src[r*IW +: IW]    = head[EW-1 -: IW];
    assign rcv_kind[r*2 +: 2]     = head[PW +: 2];
    assign rcv_data[r*PW +: PW]   = head[PW-1:0];

    // Interrupt path: single pending branch request per receiver
    msg_rr_arb #(.N(NODES)) u_irq_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (ireq),
      .take    (irq_fire[r]),
      .gnt     (igrant[r]),
      .any_req (irq_pend[r])
    );

    assign irq_fire[r] = irq_pend[r] && !brq_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        brq_q      <= 1'b0;
        brq_addr_q <= '0;
        brq_src_q  <= '0;
      end else if (irq_fire[r]) begin
        brq_q      <= 1'b1;
        brq_addr_q <= irq_addr;
        brq_src_q  <= irq_src;
      end else if (brq_ack[r]) begin
        brq_q <= 1'b0;
      end
    end

    assign brq_valid[r]         = brq_q;
    assign brq_addr[r*PW +: PW] = brq_addr_q;
    assign brq_src[r*IW +: IW]  = brq_src_q;
  end

  // Shared work queue, fed by the control node only
  logic pool_full;

  msg_work_pool #(.NPU(NUM_PU), .PW(PW), .QDEPTH(QDEPTH)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .post      (is_work[0] && !pool_full),
    .post_data (data_s[0]),
    .full      (pool_full),
    .req       (work_req),
    .wvalid    (work_valid),
    .wdata     (work_data)
  );

  // Send-side acceptance
  always_comb begin
    for (int s = 0; s < NODES; s++) begin
      snd_ready[s] = bc_fire && bc_gnt[s];
      for (int r = 0; r < NODES; r++) begin
        if (dir_fire[r] && dgnt[r][s])   snd_ready[s] = 1'b1;
        if (irq_fire[r] && igrant[r][s]) snd_ready[s] = 1'b1;
      end
      if (is_work[s]) snd_ready[s] = (s == 0) ? !pool_full : 1'b1;
    end
  end

endmodule

// File: rtl/msg_router_chk.sv
module msg_router_chk #(
  parameter int NODES = 4,
  parameter int NPU   = 3,
  parameter int PW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NODES-1:0]    snd_valid,
  input logic [NODES-1:0]    snd_ready,
  input logic [NODES-1:0]    rcv_valid,
  input logic [NODES-1:0]    rcv_pop,
  input logic [NODES-1:0]    brq_valid,
  input logic [NODES-1:0]    brq_ack,
  input logic [NODES*PW-1:0] brq_addr,
  input logic [NPU-1:0]      work_req,
  input logic [NPU-1:0]      work_valid,
  input logic [NODES-1:0]    fifo_push,
  input logic [NODES-1:0]    fifo_full,
  input logic [NODES-1:0]    dir_fire,
  input logic                bc_pend
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (rcv_valid == '0 && brq_valid == '0 && work_valid == '0));

  assert_bc_blocks_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bc_pend |-> (dir_fire == '0));

  assert_work_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(work_valid));

  for (genvar p = 0; p < NPU; p++) begin : g_pu
    assert_work_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
      work_valid[p] |-> $past(work_req[p]));
  end

  for (genvar r = 0; r < NODES; r++) begin : g_node
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push[r] |-> !fifo_full[r]);

    assert_rcv_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_valid[r] && !rcv_pop[r]) |=> rcv_valid[r]);

    assert_brq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (brq_valid[r] && !brq_ack[r]) |=> (brq_valid[r] && $stable(brq_addr[r*PW +: PW])));

    assert_ready_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      snd_ready[r] |-> snd_valid[r]);
  end

endmodule

bind msg_router msg_router_chk #(.NODES(NODES), .NPU(NUM_PU), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .snd_valid  (snd_valid),
  .snd_ready  (snd_ready),
  .rcv_valid  (rcv_valid),
  .rcv_pop    (rcv_pop),
  .brq_valid  (brq_valid),
  .brq_ack    (brq_ack),
  .brq_addr   (brq_addr),
  .work_req   (work_req),
  .work_valid (work_valid),
  .fifo_push  (fifo_push),
  .fifo_full  (fifo_full),
  .dir_fire   (dir_fire),
  .bc_pend    (bc_pend)
);

// File: tb/msg_router_test.sv
`timescale 1ns/1ps
module msg_router_test;
  localparam int NPU = 3;
  localparam int NN  = 4;
  localparam int IW  = 2;
  localparam int PW  = 8;
  localparam int FD  = 4;
  localparam int QD  = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0;

  logic [NN-1:0]    v;
  logic [IW-1:0]    dst [NN];
  logic [1:0]       knd [NN];
  logic [PW-1:0]    dat [NN];
  logic [NN*IW-1:0] snd_dest;
  logic [NN*2-1:0]  snd_kind;
  logic [NN*PW-1:0] snd_data;
  logic [NN-1:0]    snd_ready;
  logic [NN-1:0]    rcv_valid, rcv_pop, brq_valid, brq_ack;
  logic [NN*IW-1:0] rcv_src, brq_src;
  logic [NN*2-1:0]  rcv_kind;
  logic [NN*PW-1:0] rcv_data, brq_addr;
  logic [NPU-1:0]   work_req, work_valid;
  logic [PW-1:0]    work_data;

  always_comb begin
    for (int i = 0; i < NN; i++) begin
      snd_dest[i*IW +: IW] = dst[i];
      snd_kind[i*2 +: 2]   = knd[i];
      snd_data[i*PW +: PW] = dat[i];
    end
  end

  msg_router #(.NUM_PU(NPU), .PW(PW), .FDEPTH(FD), .QDEPTH(QD)) uut (
    .clk(clk), .rst_n(rst_n),
    .snd_valid(v), .snd_ready(snd_ready), .snd_dest(snd_dest),
    .snd_kind(snd_kind), .snd_data(snd_data),
    .rcv_valid(rcv_valid), .rcv_pop(rcv_pop), .rcv_src(rcv_src),
    .rcv_kind(rcv_kind), .rcv_data(rcv_data),
    .brq_valid(brq_valid), .brq_ack(brq_ack), .brq_addr(brq_addr), .brq_src(brq_src),
    .work_req(work_req), .work_valid(work_valid), .work_data(work_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic do_reset();
    v = '0; rcv_pop = '0; brq_ack = '0; work_req = '0;
    for (int i = 0; i < NN; i++) begin dst[i] = '0; knd[i] = '0; dat[i] = '0; end
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drive a message and hold it until accepted; returns on the negedge after acceptance.
  task automatic send(input int s, input int d, input int k, input int p);
    bit acc;
    @(negedge clk);
    v[s] = 1'b1; dst[s] = IW'(d); knd[s] = 2'(k); dat[s] = PW'(p);
    acc = 1'b0;
    for (int t = 0; t < 200 && !acc; t++) begin
      #1;
      acc = snd_ready[s];
      @(negedge clk);
    end
    if (!acc) check("R2", "send timeout", 0, 1);
    v[s] = 1'b0;
  endtask

  task automatic expect_msg(input int r, input int src, input int k, input int p, input string rq);
    for (int t = 0; t < 100 && !rcv_valid[r]; t++) @(negedge clk);
    check(rq, "receive valid", int'(rcv_valid[r]), 1);
    check(rq, "head {src,kind,data}",
          (int'(rcv_src[r*IW +: IW]) << 12) | (int'(rcv_kind[r*2 +: 2]) << 8) | int'(rcv_data[r*PW +: PW]),
          (src << 12) | (k << 8) | p);
    rcv_pop[r] = 1'b1;
    @(negedge clk);
    rcv_pop[r] = 1'b0;
  endtask

  int got_pu [8];
  int got_dat [8];
  int ng;
  int seen;

  initial begin
    do_reset();

    // R1: reset state
    check("R1", "rcv_valid after reset", int'(rcv_valid), 0);
    check("R1", "brq_valid after reset", int'(brq_valid), 0);
    check("R1", "work_valid after reset", int'(work_valid), 0);

    // R2: every sender/receiver pair
    for (int s = 0; s < NN; s++) begin
      for (int d = 0; d < NN; d++) begin
        send(s, d, 0, 16 * s + d + 1);
        check("R2", "only destination valid", int'(rcv_valid), 1 << d);
        expect_msg(d, s, 0, 16 * s + d + 1, "R2");
      end
    end

    // R3: broadcast from every source
    for (int s = 0; s < NN; s++) begin
      send(s, 0, 1, 8'hB0 + s);
      check("R3", "broadcast same-cycle fan-out", int'(rcv_valid), 4'hF & ~(1 << s));
      for (int r = 0; r < NN; r++) begin
        if (r != s) expect_msg(r, s, 1, 8'hB0 + s, "R3");
      end
    end

    // R7: three senders into node 0, pointer from 0 gives 1,2,3
    do_reset();
    fork
      send(1, 0, 0, 8'h11);
      send(2, 0, 0, 8'h21);
      send(3, 0, 0, 8'h31);
    join
    expect_msg(0, 1, 0, 8'h11, "R7");
    expect_msg(0, 2, 0, 8'h21, "R7");
    expect_msg(0, 3, 0, 8'h31, "R7");

    // R7: alternation between two persistent senders
    do_reset();
    @(negedge clk);
    v[1] = 1; dst[1] = 0; knd[1] = 0; dat[1] = 8'h12;
    v[3] = 1; dst[3] = 0; knd[3] = 0; dat[3] = 8'h32;
    #1 check("R7", "first grant to 1", int'({snd_ready[3], snd_ready[1]}), 2'b01);
    @(negedge clk);
    dat[1] = 8'h13;
    #1 check("R7", "second grant to 3", int'({snd_ready[3], snd_ready[1]}), 2'b10);
    @(negedge clk);
    v[3] = 0;
    #1 check("R7", "pointer wraps back to 1", int'(snd_ready[1]), 1);
    @(negedge clk);
    v[1] = 0;
    expect_msg(0, 1, 0, 8'h12, "R7");
    expect_msg(0, 3, 0, 8'h32, "R7");
    expect_msg(0, 1, 0, 8'h13, "R7");

    // R8: full receive FIFO stalls, a pop frees room
    do_reset();
    for (int i = 0; i < FD; i++) send(1, 2, 0, 8'h40 + i);
    @(negedge clk);
    v[3] = 1; dst[3] = 2; knd[3] = 0; dat[3] = 8'h4F;
    #1 check("R8", "stall on full FIFO", int'(snd_ready[3]), 0);
    repeat (3) @(negedge clk);
    #1 check("R8", "still stalled", int'(snd_ready[3]), 0);
    @(negedge clk);
    expect_msg(2, 1, 0, 8'h40, "R8");
    #1 check("R8", "accepted after pop", int'(snd_ready[3]), 1);
    @(negedge clk);
    v[3] = 0;
    for (int i = 1; i < FD; i++) expect_msg(2, 1, 0, 8'h40 + i, "R8");
    expect_msg(2, 3, 0, 8'h4F, "R8");

    // R3: broadcast held by one full FIFO, and it blocks point-to-point traffic
    do_reset();
    for (int i = 0; i < FD; i++) send(1, 2, 0, 8'h50 + i);
    @(negedge clk);
    v[0] = 1; dst[0] = 0; knd[0] = 1; dat[0] = 8'hBC;
    v[3] = 1; dst[3] = 1; knd[3] = 0; dat[3] = 8'h3D;
    #1 check("R3", "broadcast waits for room", int'(snd_ready[0]), 0);
    check("R3", "direct blocked by pending broadcast", int'(snd_ready[3]), 0);
    @(negedge clk);
    expect_msg(2, 1, 0, 8'h50, "R3");
    #1 check("R3", "broadcast fires after pop", int'({snd_ready[3], snd_ready[0]}), 2'b01);
    @(negedge clk);
    v[0] = 0;
    check("R3", "broadcast fan-out", int'(rcv_valid), 4'b1110);
    #1 check("R3", "direct proceeds after broadcast", int'(snd_ready[3]), 1);
    @(negedge clk);
    v[3] = 0;
    expect_msg(1, 0, 1, 8'hBC, "R3");
    expect_msg(1, 3, 0, 8'h3D, "R3");
    expect_msg(3, 0, 1, 8'hBC, "R3");
    for (int i = 1; i < FD; i++) expect_msg(2, 1, 0, 8'h50 + i, "R3");
    expect_msg(2, 0, 1, 8'hBC, "R3");

    // R4: work queue fill and stall
    do_reset();
    for (int i = 0; i < QD; i++) send(0, 0, 2, 8'hA0 + i);
    check("R4", "work items reach no receive port", int'(rcv_valid), 0);
    @(negedge clk);
    v[0] = 1; dst[0] = 0; knd[0] = 2; dat[0] = 8'hE0;
    #1 check("R4", "stall on full work queue", int'(snd_ready[0]), 0);
    @(negedge clk);
    v[0] = 0;
    check("R5", "no grant without request", int'(work_valid), 0);

    // R5: dispatch round-robin, oldest item first
    work_req = 3'b111;
    ng = 0;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      if (work_valid != 0 && ng < 8) begin
        got_pu[ng] = $clog2(int'(work_valid));
        got_dat[ng] = int'(work_data);
        work_req = work_req & ~work_valid;
        ng++;
      end
    end
    check("R5", "grant count", ng, 3);
    for (int i = 0; i < 3; i++) begin
      check("R5", "granted unit", got_pu[i], i);
      check("R5", "granted item", got_dat[i], 8'hA0 + i);
    end
    work_req = 3'b010;
    seen = 0;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      if (work_valid != 0) begin
        seen++;
        check("R5", "late grant unit", int'(work_valid), 3'b010);
        check("R5", "late grant item", int'(work_data), 8'hA3);
        work_req = 3'b000;
      end
    end
    check("R5", "one late grant", seen, 1);

    // R4: work item from a unit is discarded
    send(2, 0, 2, 8'hEE);
    work_req = 3'b111;
    seen = 0;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (work_valid != 0) seen++;
    end
    work_req = 3'b000;
    check("R4", "unit work item discarded", seen, 0);
    check("R4", "unit work item not in FIFOs", int'(rcv_valid), 0);

    // R6: interrupts
    do_reset();
    send(1, 0, 3, 8'h5A);
    check("R6", "branch request raised", int'(brq_valid), 4'b0001);
    check("R6", "branch target", int'(brq_addr[0 +: PW]), 8'h5A);
    check("R6", "branch source", int'(brq_src[0 +: IW]), 1);
    check("R6", "interrupt bypasses FIFO", int'(rcv_valid), 0);
    repeat (3) @(negedge clk);
    check("R6", "request held", int'(brq_valid[0]), 1);
    v[2] = 1; dst[2] = 0; knd[2] = 3; dat[2] = 8'h6B;
    v[3] = 1; dst[3] = 0; knd[3] = 3; dat[3] = 8'h7C;
    #1 check("R6", "stall while pending", int'({snd_ready[3], snd_ready[2]}), 0);
    brq_ack[0] = 1;
    @(negedge clk);
    brq_ack[0] = 0;
    #1 check("R6", "round-robin picks 2", int'({snd_ready[3], snd_ready[2]}), 2'b01);
    @(negedge clk);
    v[2] = 0;
    check("R6", "second target", int'(brq_addr[0 +: PW]), 8'h6B);
    check("R6", "second source", int'(brq_src[0 +: IW]), 2);
    #1 check("R6", "third still stalled", int'(snd_ready[3]), 0);
    @(negedge clk);
    brq_ack[0] = 1;
    @(negedge clk);
    brq_ack[0] = 0;
    #1 check("R6", "third accepted", int'(snd_ready[3]), 1);
    @(negedge clk);
    v[3] = 0;
    check("R6", "third target", int'(brq_addr[0 +: PW]), 8'h7C);
    brq_ack[0] = 1;
    @(negedge clk);
    brq_ack[0] = 0;
    check("R6", "cleared after ack", int'(brq_valid), 0);
    send(0, 2, 3, 8'h44);
    check("R6", "branch to unit", int'(brq_valid), 4'b0100);
    check("R6", "unit branch target", int'(brq_addr[2*PW +: PW]), 8'h44);
    brq_ack[2] = 1;
    @(negedge clk);
    brq_ack[2] = 0;

    summary();
    $finish;
  end

endmodule